// File: doc/BRIEF.md
# Multi-Lane Elastic Store

This block gives each of several one-bit input lanes a small ring of storage. Each lane is written on its own lane clock, and a single reference clock reads all lanes. The reference side feeds a bit-interleaving serializer, so every lane must present exactly one bit per reference cycle, whatever the phase of that lane's clock. The storage absorbs the phase difference between the two clocks. A lane whose clock phase drifts outside the tolerated window is reported on a sticky per-lane slip flag.

Each lane keeps a write position and a read position in a pointer space twice the storage depth. This makes a full ring and an empty ring look different. The write position reaches the reference domain as a cyclic one-bit-change code through a two-stage synchroniser. A low pulse on the active-low centring input, once it is released, moves every read position half the depth behind the write position that the read side last saw. This gives the most skew margin in both directions. The centring input must stay low for at least MIN_LOW reference cycles, or the block ignores it. Lanes are never aligned to one another; channel identity is restored further down the path.

Both sides stream continuously. There is no valid/ready handshake and no back-pressure. Every lane clock edge stores one bit, and every reference edge presents one bit. If the clocks differ in frequency, the fill level walks until a slip occurs. DEPTH must be even.

Top module: `elastic_store_bank`

## Requirements
- R1: With a lane clock at the reference frequency and any fixed phase, the lane's ref_bit stream equals its lane_bit stream in order, with no bit lost or repeated.
- R2: After a recognised centring, ref_bit sampled between reference edges equals the lane_bit value driven L lane cycles earlier, with DEPTH/2 <= L <= DEPTH/2+6. L stays fixed until the next centring.
- R3: A lane clock at the reference frequency, at any phase within one period, never raises slip.
- R4: slip for a lane goes to 1 when that lane's pointer separation, as seen by the read side, reaches 0 (the lane writes slower than it is read) or DEPTH (the lane writes faster).
- R5: slip is sticky. Once set, it stays 1 until a recognised centring clears it.
- R6: A low pulse on centre_n lasting fewer than MIN_LOW (default 2) reference cycles is ignored. Slip flags stay set and read timing is undisturbed.
- R7: A recognised centring clears every slip flag by the third reference edge after centre_n rises. After the start-up centring all flags read 0.
- R8: The write position crosses clocks in a cyclic code in which successive values, including the wrap from the last position to the first, differ in at most one bit.
- R9: Lanes are independent. A lane that slips does not affect the data or the slip flag of any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_clk | input | LANES | Per-lane write clock |
| lane_bit | input | LANES | Per-lane serial data, captured on the rising edge of its lane clock |
| ref_clk | input | 1 | Shared reference read clock |
| centre_n | input | 1 | Active-low centring request, acted on at release if held low for at least MIN_LOW reference cycles |
| ref_bit | output | LANES | Per-lane data to the serializer, one bit per reference cycle |
| slip | output | LANES | Sticky per-lane slip flag |

## Verification
The release of centre_n passes through two synchroniser stages, so the recentring cycle is the second reference edge after release and slip falls on the third. The bench therefore reads slip at least four reference cycles after release. The write position needs one lane edge plus two reference edges to reach the read side, and ref_bit is registered once more. For that reason the bench does not predict an exact latency. It measures the lag L from a window of 40 samples taken on falling reference edges, then holds every later sample of that lane to the same L. A lane whose frequency is 5% off needs roughly a hundred reference cycles to drift DEPTH/2 positions, so slip is checked only after 600 cycles. Lane edges are kept half a nanosecond away from reference edges, so no sample races a clock.

// File: rtl/es_pkg.sv
package es_pkg;

  // Reflected one-bit-change code of a non-negative value.
  function automatic int bin2gray(int v);
    return v ^ (v >> 1);
  endfunction

  // Inverse of bin2gray: prefix xor of all right shifts.
  function automatic int gray2bin(int g);
    int b;
    b = 0;
    for (int k = 0; k < 31; k++) b = b ^ (g >> k);
    return b;
  endfunction

endpackage

// File: rtl/es_wr_lane.sv
module es_wr_lane
  import es_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int PW    = 5,
  parameter int OFF   = 6,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             din,
  output logic [DEPTH-1:0] store,
  output logic [PW-1:0]    gray
);
  localparam int SPAN = 2 * DEPTH;

  logic [PW-1:0] bin;
  logic [PW-1:0] bin_nx;
  logic [IW-1:0] idx;
  logic          seen;

  always_comb begin
    bin_nx = (bin >= PW'(SPAN - 1)) ? '0 : bin + PW'(1);
    idx    = (bin >= PW'(DEPTH)) ? IW'(bin - PW'(DEPTH)) : IW'(bin);
  end

  // Offset code: the centre slice of the full code is itself cyclic
  // when SPAN is even, so the wrap also changes one bit.
  always_ff @(posedge clk) begin
    store[idx] <= din;
    bin        <= bin_nx;
    gray       <= PW'(bin2gray(int'(bin_nx) + OFF));
    seen       <= 1'b1;
  end

  // R8: successive codes differ in at most one bit
  p_gray_onebit_r8: assert property (@(posedge clk)
    seen |=> ($countones(gray ^ $past(gray)) <= 1))
    else $error("write code changed more than one bit");

  // R1: write position stays inside its pointer space
  p_wptr_range_r1: assert property (@(posedge clk)
    seen |-> (bin < PW'(SPAN)))
    else $error("write position out of range");

endmodule

// File: rtl/es_centre_ctl.sv
module es_centre_ctl #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic centre_n,
  output logic recentre
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic          meta;
  logic          lvl;
  logic [CW-1:0] lows;

  always_ff @(posedge clk) begin
    meta <= centre_n;
    lvl  <= meta;
    if (!lvl) lows <= (lows >= CW'(MIN_LOW)) ? lows : lows + CW'(1);
    else      lows <= '0;
  end

  assign recentre = lvl && (lows >= CW'(MIN_LOW));

  // R6: centring only follows at least two synchronised low cycles
  p_min_low_r6: assert property (@(posedge clk) disable iff (!centre_n)
    recentre |-> (!$past(lvl) && !$past(lvl, 2)))
    else $error("centring after a short low pulse");

  // R7: one centring cycle per release
  p_single_r7: assert property (@(posedge clk) disable iff (!centre_n)
    recentre |=> !recentre)
    else $error("centring lasted more than one cycle");

endmodule

// File: rtl/es_rd_lane.sv
module es_rd_lane
  import es_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int PW    = 5,
  parameter int OFF   = 6,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             centre_n,
  input  logic             recentre,
  input  logic [PW-1:0]    wgray,
  input  logic [DEPTH-1:0] store,
  output logic             dout,
  output logic             slip
);
  localparam int SPAN = 2 * DEPTH;

  logic [PW-1:0] g1, g2;
  logic [PW-1:0] wraw, wpos;
  logic [PW-1:0] rptr, rptr_nx, centre;
  logic [PW:0]   csum, ssum, sep;
  logic [IW-1:0] ridx;
  logic          hit;

  always_comb begin
    wraw    = PW'(gray2bin(int'(g2)) - OFF);
    wpos    = (wraw >= PW'(SPAN)) ? '0 : wraw;
    csum    = {1'b0, wpos} + (PW+1)'(SPAN - DEPTH / 2);
    centre  = (csum >= (PW+1)'(SPAN)) ? PW'(csum - (PW+1)'(SPAN)) : PW'(csum);
    ssum    = {1'b0, wpos} + (PW+1)'(SPAN) - {1'b0, rptr};
    sep     = (ssum >= (PW+1)'(SPAN)) ? ssum - (PW+1)'(SPAN) : ssum;
    rptr_nx = (rptr >= PW'(SPAN - 1)) ? '0 : rptr + PW'(1);
    ridx    = (rptr >= PW'(DEPTH)) ? IW'(rptr - PW'(DEPTH)) : IW'(rptr);
    hit     = (sep == '0) || (sep >= (PW+1)'(DEPTH));
  end

  always_ff @(posedge clk) begin
    g1   <= wgray;
    g2   <= g1;
    dout <= store[ridx];
    if (recentre) begin
      rptr <= centre;
      slip <= 1'b0;
    end else begin
      rptr <= rptr_nx;
      if (hit) slip <= 1'b1;
    end
  end

  // R2: right after centring the separation sits at half depth plus sync drift
  p_centred_r2: assert property (@(posedge clk) disable iff (!centre_n)
    recentre |=> (sep >= (PW+1)'(DEPTH / 2) && sep <= (PW+1)'(DEPTH / 2 + 2)))
    else $error("separation not centred");

  // R7: centring clears the flag
  p_cleared_r7: assert property (@(posedge clk) disable iff (!centre_n)
    recentre |=> !slip)
    else $error("slip not cleared by centring");

  // R5: flag is sticky
  p_sticky_r5: assert property (@(posedge clk) disable iff (!centre_n)
    (slip && !recentre) |=> slip)
    else $error("slip dropped without centring");

  // R4: flag only rises on an empty or full separation
  p_slip_cause_r4: assert property (@(posedge clk) disable iff (!centre_n)
    $rose(slip) |-> ($past(sep) == '0 || $past(sep) >= (PW+1)'(DEPTH)))
    else $error("slip without a boundary separation");

endmodule

// File: rtl/elastic_store_bank.sv
module elastic_store_bank #(
  parameter int LANES   = 4,
  parameter int DEPTH   = 10,
  parameter int MIN_LOW = 2
) (
  input  logic [LANES-1:0] lane_clk,
  input  logic [LANES-1:0] lane_bit,
  input  logic             ref_clk,
  input  logic             centre_n,
  output logic [LANES-1:0] ref_bit,
  output logic [LANES-1:0] slip
);
  localparam int SPAN = 2 * DEPTH;
  localparam int PW   = $clog2(SPAN);
  localparam int OFF  = ((1 << PW) - SPAN) / 2;
  localparam int IW   = $clog2(DEPTH);

  logic recentre;

  es_centre_ctl #(.MIN_LOW(MIN_LOW)) u_ctl (
    .clk      (ref_clk),
    .centre_n (centre_n),
    .recentre (recentre)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DEPTH-1:0] store;
    logic [PW-1:0]    gray;

    es_wr_lane #(.DEPTH(DEPTH), .PW(PW), .OFF(OFF), .IW(IW)) u_wr (
      .clk   (lane_clk[g]),
      .din   (lane_bit[g]),
      .store (store),
      .gray  (gray)
    );

    es_rd_lane #(.DEPTH(DEPTH), .PW(PW), .OFF(OFF), .IW(IW)) u_rd (
      .clk      (ref_clk),
      .centre_n (centre_n),
      .recentre (recentre),
      .wgray    (gray),
      .store    (store),
      .dout     (ref_bit[g]),
      .slip     (slip[g])
    );
  end

endmodule

// File: tb/elastic_store_bank_test.sv
`timescale 1ns/1ps
module elastic_store_bank_test;
  localparam int LANES = 4;
  localparam int DEPTH = 10;
  localparam int NS    = 40;

  logic ref_clk  = 1'b0;
  logic centre_n = 1'b0;
  wire [LANES-1:0] lane_clk, lane_bit, ref_bit, slip;

  real hp [LANES] = '{4.0, 4.0, 4.0, 4.0};
  real sh [LANES] = '{0.5, 0.5, 0.5, 0.5};
  int  wcnt [LANES] = '{0, 0, 0, 0};
  int  lag [LANES];
  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #4 ref_clk = ~ref_clk;   // 125 MHz

  function automatic bit pat(int i, int n);
    logic [31:0] h;
    h = (32'(n) * 32'h9E3779B1) ^ (32'(i) * 32'h85EBCA6B);
    h = h ^ (h >> 15);
    h = h * 32'h2C1B3C6D;
    h = h ^ (h >> 12);
    return h[3];
  endfunction

  for (genvar gv = 0; gv < LANES; gv++) begin : g_src
    logic ck = 1'b0;
    logic b  = 1'b0;
    always begin
      if (sh[gv] > 0.0) begin
        #(sh[gv]);
        sh[gv] = 0.0;
      end
      #(hp[gv]);
      ck = ~ck;
    end
    always @(negedge ck) begin
      b        <= pat(gv, wcnt[gv]);
      wcnt[gv] <= wcnt[gv] + 1;
    end
    assign lane_clk[gv] = ck;
    assign lane_bit[gv] = b;
  end

  elastic_store_bank #(.LANES(LANES), .DEPTH(DEPTH), .MIN_LOW(2)) uut (
    .lane_clk (lane_clk),
    .lane_bit (lane_bit),
    .ref_clk  (ref_clk),
    .centre_n (centre_n),
    .ref_bit  (ref_bit),
    .slip     (slip)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    @(negedge ref_clk) centre_n = 1'b0;
    repeat (n) @(negedge ref_clk);
    centre_n = 1'b1;
  endtask

  task automatic find_lags();
    int sd [LANES][NS];
    int sw [LANES][NS];
    for (int k = 0; k < NS; k++) begin
      @(negedge ref_clk);
      for (int i = 0; i < LANES; i++) begin
        sd[i][k] = int'(ref_bit[i]);
        sw[i][k] = wcnt[i];
      end
    end
    for (int i = 0; i < LANES; i++) begin
      lag[i] = -1;
      for (int l = 0; l <= 2 * DEPTH + 4; l++) begin
        bit ok;
        ok = 1'b1;
        for (int k = 0; k < NS; k++)
          if (sw[i][k] - 1 - l < 0 || sd[i][k] != int'(pat(i, sw[i][k] - 1 - l))) ok = 1'b0;
        if (ok && lag[i] < 0) lag[i] = l;
      end
    end
  endtask

  task automatic stream_check(input int n, input logic [LANES-1:0] mask, input string req);
    int bad [LANES] = '{default: 0};
    for (int k = 0; k < n; k++) begin
      @(negedge ref_clk);
      for (int i = 0; i < LANES; i++)
        if (mask[i] && ref_bit[i] != pat(i, wcnt[i] - 1 - lag[i])) bad[i]++;
    end
    for (int i = 0; i < LANES; i++)
      if (mask[i]) check(bad[i] == 0, req, $sformatf("lane %0d stream mismatches", i), bad[i], 0);
  endtask

  initial begin
    // start-up centring, R7 reset state
    repeat (5) @(negedge ref_clk);
    centre_n = 1'b1;
    repeat (6) @(negedge ref_clk);
    check(slip == '0, "R7", "slip after start-up centring", int'(slip), 0);

    // phase sweep at equal frequency: R1, R2, R3
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < LANES; i++) sh[i] = real'((3 * t + 2 * i + 1) % 8);
      repeat (3) @(negedge ref_clk);
      pulse(4);
      repeat (30) @(negedge ref_clk);
      find_lags();
      for (int i = 0; i < LANES; i++)
        check(lag[i] >= DEPTH / 2 && lag[i] <= DEPTH / 2 + 6, "R2",
              $sformatf("lane %0d lag after centring", i), lag[i], DEPTH / 2);
      stream_check(200, '1, "R1");
      for (int i = 0; i < LANES; i++)
        check(slip[i] == 1'b0, "R3", $sformatf("lane %0d slip at equal rate", i),
              int'(slip[i]), 0);
    end

    // frequency offset: lane 1 writes fast, lane 2 slow (R4, R9)
    hp[1] = 3.8;
    hp[2] = 4.2;
    pulse(4);
    repeat (20) @(negedge ref_clk);
    check(slip == '0, "R7", "slip shortly after centring", int'(slip), 0);
    repeat (600) @(negedge ref_clk);
    check(slip[1] == 1'b1, "R4", "fast lane slip", int'(slip[1]), 1);
    check(slip[2] == 1'b1, "R4", "slow lane slip", int'(slip[2]), 1);
    check(slip[0] == 1'b0 && slip[3] == 1'b0, "R9", "steady lanes untouched",
          int'({slip[3], slip[0]}), 0);

    // restore rates: flags must stay (R5), short pulse ignored (R6)
    hp[1] = 4.0;
    hp[2] = 4.0;
    repeat (20) @(negedge ref_clk);
    check(slip[1] && slip[2], "R5", "flags held after rates restored",
          int'({slip[2], slip[1]}), 3);
    find_lags();
    pulse(1);
    repeat (10) @(negedge ref_clk);
    check(slip[1] && slip[2], "R6", "flags kept over short pulse",
          int'({slip[2], slip[1]}), 3);
    stream_check(100, 4'b1001, "R6");

    // recognised centring clears all flags (R5, R7)
    pulse(3);
    repeat (6) @(negedge ref_clk);
    check(slip == '0, "R5", "flags cleared by centring", int'(slip), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8.0);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule